// File: doc/BRIEF.md
# Auto-Stepping Data Pointer Unit

This block holds a small set of 16-bit data pointers for an 8051-style processor core and drives the currently selected one onto the address used by external data accesses and code-table reads. The instruction decoder, the memories and the ALU sit outside. They reach the block through a decoded access-class code, a pointer select, a control register write port, and strobes for an explicit 16-bit load, a byte write and an explicit increment.

A control register can arm an automatic post-modify. When it is armed, each of three memory-access classes moves the selected pointer by one once the access has used it: a code read at accumulator plus pointer, an external data read, and an external data write. Each pointer has its own direction bit, which makes the step an increment or a decrement. The explicit load and the explicit increment never add a further step. A byte write overrides the step in the same cycle.

Top module: `dptr_unit`

## Requirements
- R1: While reset is asserted, every pointer reads 0x0000 and the control register reads 0x00, so auto-modify is off.
- R2: `addr` always shows the selected pointer. During a triggering access it shows the value from before the step, and the stepped value is visible from the next cycle.
- R3: Control bit 3 arms auto-modify. Bit 4+i sets the direction of pointer i (0 = up, 1 = down). All other bits read as 0. A write shows on `ctl_q` from the next cycle.
- R4: When armed, access class 3'd1 (code read), 3'd2 (external read) or 3'd3 (external write) moves the selected pointer by exactly one in its direction. Classes 3'd0 and 3'd4 to 3'd7 cause no step.
- R5: With control bit 3 at 0, no access class changes any pointer.
- R6: Steps wrap modulo 2^16: 0xFFFF steps up to 0x0000, and 0x0000 steps down to 0xFFFF.
- R7: `ld_en` loads `ld_data` into the selected pointer, with no automatic step, whatever the access class. It has the highest priority.
- R8: `inc_en` adds exactly 1 to the selected pointer, whatever the direction bit. No automatic step is added, even with a triggering class.
- R9: Pointers that are not selected keep their values under every strobe and class.
- R10: `bw_en` replaces one byte of the selected pointer (`bw_hi`=1 for the high byte, 0 for the low byte) and leaves the other byte as it was. It takes priority over the explicit increment and the automatic step.
- R11: `rd_byte` gives the high byte of the selected pointer when `bw_hi` is 1, and the low byte when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_cls | input | 3 | Decoded access class of the current instruction |
| ptr_sel | input | 1 | Selected pointer index |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ld_en | input | 1 | Explicit 16-bit load of the selected pointer |
| ld_data | input | 16 | Load value |
| bw_en | input | 1 | Byte write to the selected pointer |
| bw_hi | input | 1 | Byte choice for byte write and byte read |
| bw_data | input | 8 | Byte write value |
| inc_en | input | 1 | Explicit increment of the selected pointer |
| addr | output | 16 | Selected pointer value |
| rd_byte | output | 8 | Chosen byte of the selected pointer |
| ctl_q | output | 8 | Control register contents |

## Verification
The assertions assume that the pointer select and the strobes are stable over each clock edge. They also assume that the control register value used for a step is the one held before that edge, so a control write and a triggering access in the same cycle act on the old setting. The stimulus changes inputs only at falling edges. It never writes the control register in the cycle of a triggering access, and it combines strobes only in the override cases that the requirements define. Every step outcome is therefore fixed by values that were already in place at the preceding edge.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned PTR_W  = 16;
  localparam int unsigned CTL_W  = 8;
  localparam int unsigned EN_BIT = 3;
  localparam int unsigned DIR_LSB = 4;

  localparam logic [2:0] ACC_NONE = 3'd0;
  localparam logic [2:0] ACC_CODE = 3'd1;
  localparam logic [2:0] ACC_XRD  = 3'd2;
  localparam logic [2:0] ACC_XWR  = 3'd3;

  function automatic logic acc_triggers(input logic [2:0] cls);
    return (cls == ACC_CODE) || (cls == ACC_XRD) || (cls == ACC_XWR);
  endfunction
endpackage

// File: rtl/dptr_rst_sync.sv
module dptr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/dptr_ctl.sv
module dptr_ctl
  import dptr_pkg::*;
#(
  parameter int unsigned NUM_PTR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CTL_W-1:0]   wdata,
  output logic [CTL_W-1:0]   q,
  output logic               auto_on,
  output logic [NUM_PTR-1:0] dir_dn
);
  localparam logic [CTL_W-1:0] DIR_MASK = CTL_W'(((1 << NUM_PTR) - 1) << DIR_LSB);
  localparam logic [CTL_W-1:0] WR_MASK  = DIR_MASK | CTL_W'(1 << EN_BIT);

  logic [CTL_W-1:0] nxt;

  always_comb begin
    nxt = wdata & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= nxt;
  end

  assign auto_on = q[EN_BIT];
  assign dir_dn  = q[DIR_LSB +: NUM_PTR];
endmodule

// File: rtl/dptr_slot.sv
module dptr_slot #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          ld_en,
  input  logic [PW-1:0] ld_data,
  input  logic          bw_en,
  input  logic          bw_hi,
  input  logic [7:0]    bw_data,
  input  logic          inc_en,
  input  logic          auto_go,
  input  logic          dir_dn,
  output logic [PW-1:0] q
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] nxt;
  logic          upd;

  always_comb begin
    nxt = q;
    upd = 1'b0;
    if (hit) begin
      if (ld_en) begin
        nxt = ld_data;
        upd = 1'b1;
      end else if (bw_en) begin
        upd = 1'b1;
        if (bw_hi) nxt[PW-1:8] = bw_data;
        else       nxt[7:0]    = bw_data;
      end else if (inc_en) begin
        nxt = q + ONE;
        upd = 1'b1;
      end else if (auto_go) begin
        nxt = dir_dn ? (q - ONE) : (q + ONE);
        upd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
  import dptr_pkg::*;
#(
  parameter int unsigned NUM_PTR = 2,
  parameter int unsigned PW      = PTR_W,
  localparam int unsigned SW     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       acc_cls,
  input  logic [SW-1:0]    ptr_sel,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ld_en,
  input  logic [PW-1:0]    ld_data,
  input  logic             bw_en,
  input  logic             bw_hi,
  input  logic [7:0]       bw_data,
  input  logic             inc_en,
  output logic [PW-1:0]    addr,
  output logic [7:0]       rd_byte,
  output logic [CTL_W-1:0] ctl_q
);
  logic                         rst_sync_n;
  logic                         auto_on;
  logic [NUM_PTR-1:0]           dir_dn;
  logic                         auto_go;
  logic [NUM_PTR-1:0][PW-1:0]   ptrs;

  dptr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dptr_ctl #(.NUM_PTR(NUM_PTR)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .q       (ctl_q),
    .auto_on (auto_on),
    .dir_dn  (dir_dn)
  );

  assign auto_go = auto_on && acc_triggers(acc_cls);

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_slot
    dptr_slot #(.PW(PW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .hit     (ptr_sel == SW'(i)),
      .ld_en   (ld_en),
      .ld_data (ld_data),
      .bw_en   (bw_en),
      .bw_hi   (bw_hi),
      .bw_data (bw_data),
      .inc_en  (inc_en),
      .auto_go (auto_go),
      .dir_dn  (dir_dn[i]),
      .q       (ptrs[i])
    );
  end

  always_comb begin
    addr = '0;
    for (int k = 0; k < NUM_PTR; k++) begin
      if (ptr_sel == SW'(k)) addr = ptrs[k];
    end
  end

  assign rd_byte = bw_hi ? addr[PW-1:8] : addr[7:0];
endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk
  import dptr_pkg::*;
#(
  parameter int unsigned NUM_PTR = 2,
  parameter int unsigned PW      = PTR_W,
  localparam int unsigned SW     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2:0]                 acc_cls,
  input logic [SW-1:0]              ptr_sel,
  input logic                       ctl_we,
  input logic [CTL_W-1:0]           ctl_wdata,
  input logic                       ld_en,
  input logic [PW-1:0]              ld_data,
  input logic                       bw_en,
  input logic                       bw_hi,
  input logic [7:0]                 bw_data,
  input logic                       inc_en,
  input logic [PW-1:0]              addr,
  input logic [CTL_W-1:0]           ctl_q,
  input logic [NUM_PTR-1:0][PW-1:0] ptrs
);
  logic          strobe_any;
  logic          trig;
  logic          sel_dn;
  logic [PW-1:0] stepped;

  assign strobe_any = ld_en || bw_en || inc_en;
  assign trig       = acc_triggers(acc_cls) && ctl_q[EN_BIT] && !strobe_any;
  assign sel_dn     = ctl_q[DIR_LSB + 32'(ptr_sel)];
  assign stepped    = sel_dn ? (addr - PW'(1)) : (addr + PW'(1));

  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> ptrs[$past(ptr_sel)] == $past(stepped)); // R4

  AST_NO_STEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[EN_BIT] && !strobe_any) |=> $stable(ptrs)); // R5

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ptrs[$past(ptr_sel)] == $past(ld_data)); // R7

  AST_EXPL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !ld_en && !bw_en) |=> ptrs[$past(ptr_sel)] == $past(addr) + PW'(1)); // R8

  AST_BYTE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_en && !ld_en && !bw_hi) |=>
      ptrs[$past(ptr_sel)] == {$past(addr[PW-1:8]), $past(bw_data)}); // R10

  AST_BYTE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_en && !ld_en && bw_hi) |=>
      ptrs[$past(ptr_sel)] == {$past(bw_data), $past(addr[7:0])}); // R10

  AST_CTL_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_q[EN_BIT] == $past(ctl_wdata[EN_BIT])); // R3

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_keep
    AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_sel != SW'(i)) |=> $stable(ptrs[i])); // R9
  end
endmodule

bind dptr_unit dptr_unit_chk #(.NUM_PTR(NUM_PTR), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_cls   (acc_cls),
  .ptr_sel   (ptr_sel),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ld_en     (ld_en),
  .ld_data   (ld_data),
  .bw_en     (bw_en),
  .bw_hi     (bw_hi),
  .bw_data   (bw_data),
  .inc_en    (inc_en),
  .addr      (addr),
  .ctl_q     (ctl_q),
  .ptrs      (ptrs)
);

// File: tb/dptr_unit_tb.sv
module dptr_unit_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_LIMIT   = 5000;

  typedef struct packed {
    logic        cw;
    logic [7:0]  cd;
    logic        sel;
    logic [2:0]  cls;
    logic        ld;
    logic [15:0] ldd;
    logic        bw;
    logic        bh;
    logic [7:0]  bd;
    logic        inc;
    logic        chk;
    logic [15:0] exp_v;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    // cw  cd     sel  cls   ld  ldd       bw  bh  bd     inc chk exp        req
    '{1'b0,8'h00,1'b0,3'd0,1'b1,16'h1234,1'b0,1'b0,8'h00,1'b0,1'b0,16'h1234,4'd7},  // R7
    '{1'b0,8'h00,1'b1,3'd1,1'b1,16'hFFFF,1'b0,1'b0,8'h00,1'b0,1'b1,16'hFFFF,4'd7},  // R7
    '{1'b0,8'h00,1'b0,3'd2,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b0,16'h1234,4'd5},  // R5
    '{1'b1,8'h08,1'b0,3'd0,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b0,16'h1234,4'd3},  // R3
    '{1'b0,8'h00,1'b0,3'd2,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b0,16'h1235,4'd4},  // R4
    '{1'b0,8'h00,1'b0,3'd3,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b0,16'h1236,4'd4},  // R4
    '{1'b0,8'h00,1'b0,3'd1,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b0,16'h1237,4'd4},  // R4
    '{1'b0,8'h00,1'b0,3'd4,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b0,16'h1237,4'd4},  // R4
    '{1'b0,8'h00,1'b1,3'd1,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b1,16'h0000,4'd6},  // R6
    '{1'b0,8'h00,1'b0,3'd1,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b1,16'h0000,4'd9},  // R9
    '{1'b1,8'h28,1'b1,3'd0,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b1,16'h0000,4'd3},  // R3
    '{1'b0,8'h00,1'b1,3'd2,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b1,16'hFFFF,4'd6},  // R6
    '{1'b0,8'h00,1'b0,3'd2,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b0,16'h1239,4'd4},  // R4
    '{1'b0,8'h00,1'b1,3'd3,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b1,1'b1,16'h0000,4'd8},  // R8
    '{1'b0,8'h00,1'b1,3'd2,1'b1,16'h0100,1'b0,1'b0,8'h00,1'b0,1'b1,16'h0100,4'd7},  // R7
    '{1'b0,8'h00,1'b1,3'd2,1'b0,16'h0000,1'b1,1'b0,8'h55,1'b0,1'b1,16'h0155,4'd10}, // R10
    '{1'b0,8'h00,1'b1,3'd0,1'b0,16'h0000,1'b1,1'b1,8'hAA,1'b1,1'b1,16'hAA55,4'd10}, // R10
    '{1'b1,8'h00,1'b1,3'd0,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b1,16'hAA55,4'd3},  // R3
    '{1'b0,8'h00,1'b1,3'd3,1'b0,16'h0000,1'b0,1'b0,8'h00,1'b0,1'b1,16'hAA55,4'd5}   // R5
  };

  logic        clk;
  logic        rst_n;
  logic [2:0]  acc_cls;
  logic        ptr_sel;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic        ld_en;
  logic [15:0] ld_data;
  logic        bw_en;
  logic        bw_hi;
  logic [7:0]  bw_data;
  logic        inc_en;
  logic [15:0] addr;
  logic [7:0]  rd_byte;
  logic [7:0]  ctl_q;

  int total;
  int bad;
  int cycles;

  dptr_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_cls   (acc_cls),
    .ptr_sel   (ptr_sel),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ld_en     (ld_en),
    .ld_data   (ld_data),
    .bw_en     (bw_en),
    .bw_hi     (bw_hi),
    .bw_data   (bw_data),
    .inc_en    (inc_en),
    .addr      (addr),
    .rd_byte   (rd_byte),
    .ctl_q     (ctl_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        total++;
        bad++;
        $display("FAIL watchdog act=%0d cycles exp<=%0d", cycles, WD_LIMIT);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp_v);
    end
  endtask

  task automatic idle(input logic sel);
    acc_cls   = 3'd0;
    ptr_sel   = sel;
    ctl_we    = 1'b0;
    ctl_wdata = 8'h00;
    ld_en     = 1'b0;
    ld_data   = 16'h0000;
    bw_en     = 1'b0;
    bw_hi     = 1'b0;
    bw_data   = 8'h00;
    inc_en    = 1'b0;
  endtask

  initial begin
    total = 0;
    bad   = 0;
    idle(1'b0);
    rst_n = 1'b0;
    #1;
    // R1: reset state
    check("R1 addr", addr, 16'h0000);
    check("R1 ctl", {8'h00, ctl_q}, 16'h0000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ptr_sel = 1'b1;
    #1;
    check("R1 p1", addr, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      acc_cls   = VEC[v].cls;
      ptr_sel   = VEC[v].sel;
      ctl_we    = VEC[v].cw;
      ctl_wdata = VEC[v].cd;
      ld_en     = VEC[v].ld;
      ld_data   = VEC[v].ldd;
      bw_en     = VEC[v].bw;
      bw_hi     = VEC[v].bh;
      bw_data   = VEC[v].bd;
      inc_en    = VEC[v].inc;
      @(negedge clk);
      idle(VEC[v].chk);
      #1;
      check($sformatf("R%0d vec%0d", VEC[v].req, v), addr, VEC[v].exp_v);
    end

    // R3: unused control bits read back as zero
    @(negedge clk);
    ctl_we    = 1'b1;
    ctl_wdata = 8'hFF;
    @(negedge clk);
    idle(1'b0);
    #1;
    check("R3 mask", {8'h00, ctl_q}, 16'h0038);

    // R2: pre-step address during the access, stepped value next cycle
    @(negedge clk);
    ptr_sel = 1'b0;
    acc_cls = 3'd2;
    #1;
    check("R2 pre", addr, 16'h1239);
    @(negedge clk);
    idle(1'b0);
    #1;
    check("R2 post", addr, 16'h1238);

    // R11: byte readout of pointer 1
    ptr_sel = 1'b1;
    bw_hi   = 1'b1;
    #1;
    check("R11 hi", {8'h00, rd_byte}, 16'h00AA);
    bw_hi = 1'b0;
    #1;
    check("R11 lo", {8'h00, rd_byte}, 16'h0055);

    // R1: asynchronous reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid addr", addr, 16'h0000);
    check("R1 mid ctl", {8'h00, ctl_q}, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule